// File: doc/BRIEF.md
# Rotate-and-Mask Logic Unit

This unit executes the two immediate rotate-then-mask operations of a fixed-point pipeline. It takes a 32-bit instruction word and a 64-bit source operand, recognises the two supported encodings, and returns the rotated and masked result one clock later. The word form works on the low 32 bits of the source. The doubleword form works on all 64 bits. When the record bit is set, a 4-bit condition nibble is also produced from the result.

Bits are numbered big-endian: bit 0 is the most significant bit of the 64-bit value. In the word form, the mask bounds are offset by 32 so they land in the low word. A logical right shift has no separate path: it is written as a rotate plus a mask. The register file and any other decoding live outside the unit. The instruction word arrives with its primary opcode in bits 31:26 of `in_insn`. The bit positions below use the big-endian numbering of the instruction word: bit 0 is `in_insn[31]` and bit 31 is `in_insn[0]`.

Top module: `rotmask_unit`

## Requirements
- R1: An instruction is accepted only in two cases. The first is primary opcode 21 (word form). The second is primary opcode 30 with instruction bits 27-29 all zero (doubleword form). Any other instruction word leaves `out_valid` and `out_cr0_we` low in the following cycle.
- R2: An accepted instruction presented with `in_valid` in one cycle sets `out_valid` and its result on the next rising edge, and not before. A cycle without `in_valid` gives `out_valid` low. Reset clears `out_valid`, `out_result` and `out_cr0_we`.
- R3: In the word form, SH is instruction bits 16-20, MB is bits 21-25, ME is bits 26-30 and Rc is bit 31. The low 32 source bits are rotated left by SH. When MB <= ME, they are ANDed with a mask whose ones run from big-endian bit MB+32 through ME+32.
- R4: In the word form, when MB > ME the mask wraps around. It has ones from big-endian bit MB+32 through 63 and from 32 through ME+32.
- R5: In the word form, result bits 0-31 (big-endian) are always zero. The upper 32 source bits have no effect on the result.
- R6: In the doubleword form, the 6-bit SH is built with instruction bit 30 as its most significant bit above bits 16-20. The 6-bit MB is built with bit 26 as its most significant bit above bits 21-25. The 64-bit source is rotated left by SH and ANDed with a mask of ones from big-endian bit MB through 63.
- R7: A logical right shift by n is obtained as a rotate plus a mask. For the low word, use the word form with SH=32-n, MB=n, ME=31. For the full 64 bits, use the doubleword form with SH=64-n, MB=n. Both give the source shifted right by n.
- R8: Source 0x11223344556677A8 in the word form with SH=27, MB=31, ME=31 gives 0x0000000000000001.
- R9: `out_cr0_we` equals the Rc bit of the accepted instruction, and it is low when Rc=0. `out_cr0` is {LT,GT,EQ,SO}, with bit 3 = LT (result negative as a signed 64-bit value), bit 2 = GT (positive), bit 1 = EQ (zero) and bit 0 = SO, which is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and source are present this cycle |
| in_insn | input | 32 | Instruction word, primary opcode in bits 31:26 |
| in_src | input | 64 | Source operand |
| out_valid | output | 1 | Result of an accepted instruction is present |
| out_result | output | 64 | Rotated and masked result |
| out_cr0_we | output | 1 | Condition nibble is to be written |
| out_cr0 | output | 4 | Condition nibble {LT,GT,EQ,SO} |

## Verification
The checker watches every cycle for the following:
- rejected encodings never raise `out_valid`;
- the one-cycle latency holds;
- the upper word of a word-form result is always clear;
- the bits left of MB in a doubleword result are always clear;
- the condition nibble follows the record bit and carries exactly one of LT, GT and EQ.

The exact rotated values, the wrapped masks, the right-shift equivalences, the specific example vector and the signed compare behind the nibble can only be shown by the bench. The bench sweeps every SH, MB and ME combination of the word form, every SH and MB pair of the doubleword form, and every rejected opcode.

// File: rtl/rmx_pkg.sv
package rmx_pkg;

   typedef enum logic [1:0] {
      FORM_NONE  = 2'd0,
      FORM_WORD  = 2'd1,
      FORM_DWORD = 2'd2
   } form_e;

   localparam int FLD_W = 6;

   typedef struct packed {
      form_e            form;
      logic [FLD_W-1:0] sh;
      logic [FLD_W-1:0] mb;
      logic [FLD_W-1:0] me;
      logic             rc;
   } fields_t;

endpackage

// File: rtl/rmx_decode.sv
module rmx_decode
   import rmx_pkg::*;
#(
   parameter int IW        = 32,
   parameter int OPC_W     = 6,
   parameter int OPC_WORD  = 21,
   parameter int OPC_DWORD = 30
) (
   input  logic [IW-1:0] insn,
   output fields_t       fld
);

   localparam int SUB_W = FLD_W - 1;

   if (IW != 32) begin : g_bad_iw
      $error("rmx_decode: instruction width must be 32");
   end
   if (OPC_W != 6) begin : g_bad_opc
      $error("rmx_decode: primary opcode width must be 6");
   end

   logic [OPC_W-1:0] opc;
   logic [2:0]       xo;
   logic [SUB_W-1:0] f_sh_lo;
   logic [SUB_W-1:0] f_mb_lo;
   logic [SUB_W-1:0] f_me;
   logic             is_word;
   logic             is_dword;
   logic             unused_regs;

   assign opc         = insn[IW-1 -: OPC_W];
   assign xo          = insn[4:2];
   assign f_sh_lo     = insn[15:11];
   assign f_mb_lo     = insn[10:6];
   assign f_me        = insn[5:1];
   assign unused_regs = ^insn[25:16];

   assign is_word  = (opc == OPC_W'(OPC_WORD));
   assign is_dword = (opc == OPC_W'(OPC_DWORD)) && (xo == 3'b000);

   always_comb begin
      fld    = '0;
      fld.rc = insn[0];
      if (is_word) begin
         fld.form = FORM_WORD;
         fld.sh   = {1'b0, f_sh_lo};
         fld.mb   = {1'b0, f_mb_lo};
         fld.me   = {1'b0, f_me};
      end else if (is_dword) begin
         fld.form = FORM_DWORD;
         fld.sh   = {insn[1], f_sh_lo};
         fld.mb   = {insn[5], f_mb_lo};
         fld.me   = '0;
      end else begin
         fld.form = FORM_NONE;
      end
   end

endmodule

// File: rtl/rmx_rotator.sv
module rmx_rotator #(
   parameter int DW = 64,
   localparam int AW = $clog2(DW),
   localparam int HW = DW / 2
) (
   input  logic [DW-1:0] din,
   input  logic          word_mode,
   input  logic [AW-1:0] amt,
   output logic [DW-1:0] dout
);

   if ((DW & (DW - 1)) != 0 || DW < 8) begin : g_bad_dw
      $error("rmx_rotator: DW must be a power of two of at least 8");
   end

   logic [DW-1:0] stg [0:AW];

   assign stg[0] = word_mode ? {din[HW-1:0], din[HW-1:0]} : din;

   for (genvar s = 0; s < AW; s++) begin : g_stage
      localparam int STEP = 1 << s;
      assign stg[s+1] = amt[s] ? {stg[s][DW-1-STEP:0], stg[s][DW-1 -: STEP]}
                               : stg[s];
   end

   assign dout = stg[AW];

endmodule

// File: rtl/rmx_maskgen.sv
module rmx_maskgen #(
   parameter int DW = 64,
   localparam int AW = $clog2(DW),
   localparam int HW = DW / 2
) (
   input  logic          word_mode,
   input  logic [AW-1:0] mb,
   input  logic [AW-1:0] me,
   output logic [DW-1:0] mask
);

   logic no_wrap;
   assign no_wrap = (mb <= me);

   for (genvar j = 0; j < DW; j++) begin : g_bit
      localparam int            BE  = DW - 1 - j;
      localparam logic [AW-1:0] BEV = AW'(BE);
      logic dw_bit;
      assign dw_bit = (BEV >= mb);
      if (j >= HW) begin : g_hi
         assign mask[j] = word_mode ? 1'b0 : dw_bit;
      end else begin : g_lo
         localparam logic [AW-1:0] KWV = AW'(BE - HW);
         logic wd_bit;
         assign wd_bit = no_wrap ? ((KWV >= mb) && (KWV <= me))
                                 : ((KWV >= mb) || (KWV <= me));
         assign mask[j] = word_mode ? wd_bit : dw_bit;
      end
   end

endmodule

// File: rtl/rmx_cr0.sv
module rmx_cr0 #(
   parameter int DW = 64
) (
   input  logic [DW-1:0] res,
   output logic [3:0]    cr
);

   logic neg;
   logic zero;

   assign neg  = res[DW-1];
   assign zero = (res == '0);
   assign cr   = {neg, !neg && !zero, zero, 1'b0};

endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
   import rmx_pkg::*;
#(
   parameter int DW        = 64,
   parameter int IW        = 32,
   parameter bit REG_OUT   = 1'b1,
   parameter int OPC_WORD  = 21,
   parameter int OPC_DWORD = 30
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [IW-1:0] in_insn,
   input  logic [DW-1:0] in_src,
   output logic          out_valid,
   output logic [DW-1:0] out_result,
   output logic          out_cr0_we,
   output logic [3:0]    out_cr0
);

   localparam int AW = $clog2(DW);

   if (DW != 64) begin : g_bad_dw
      $error("rotmask_unit: operand width must be 64");
   end
   if (AW != FLD_W) begin : g_bad_aw
      $error("rotmask_unit: rotate amount width mismatch");
   end

   fields_t       fld;
   logic          word_mode;
   logic          hit;
   logic [DW-1:0] rot;
   logic [DW-1:0] mask;
   logic [DW-1:0] res_c;
   logic [3:0]    cr_c;

   rmx_decode #(
      .IW(IW), .OPC_W(6), .OPC_WORD(OPC_WORD), .OPC_DWORD(OPC_DWORD)
   ) u_dec (
      .insn(in_insn),
      .fld (fld)
   );

   assign word_mode = (fld.form == FORM_WORD);
   assign hit       = in_valid && (fld.form != FORM_NONE);

   rmx_rotator #(.DW(DW)) u_rot (
      .din      (in_src),
      .word_mode(word_mode),
      .amt      (fld.sh),
      .dout     (rot)
   );

   rmx_maskgen #(.DW(DW)) u_mask (
      .word_mode(word_mode),
      .mb       (fld.mb),
      .me       (fld.me),
      .mask     (mask)
   );

   assign res_c = rot & mask;

   rmx_cr0 #(.DW(DW)) u_cr0 (
      .res(res_c),
      .cr (cr_c)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_cr0_we <= 1'b0;
            out_cr0    <= '0;
         end else begin
            out_valid  <= hit;
            out_cr0_we <= hit && fld.rc;
            if (hit) begin
               out_result <= res_c;
               out_cr0    <= cr_c;
            end
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign out_valid  = hit;
      assign out_result = res_c;
      assign out_cr0_we = hit && fld.rc;
      assign out_cr0    = cr_c;
   end

endmodule

// File: rtl/rotmask_unit_chk.sv
module rotmask_unit_chk #(
   parameter int DW        = 64,
   parameter int IW        = 32,
   parameter bit REG_OUT   = 1'b1,
   parameter int OPC_WORD  = 21,
   parameter int OPC_DWORD = 30
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic [IW-1:0] in_insn,
   input logic          out_valid,
   input logic [DW-1:0] out_result,
   input logic          out_cr0_we,
   input logic [3:0]    out_cr0
);

   logic [5:0] opc;
   logic       c_word;
   logic       c_dword;
   logic       c_known;
   logic [5:0] c_mb;

   assign opc     = in_insn[IW-1 -: 6];
   assign c_word  = (opc == 6'(OPC_WORD));
   assign c_dword = (opc == 6'(OPC_DWORD)) && (in_insn[4:2] == 3'b000);
   assign c_known = c_word || c_dword;
   assign c_mb    = {in_insn[5], in_insn[10:6]};

   AST_CR0_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_cr0_we |-> out_valid);  // R9
   AST_CR0_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      out_cr0_we |-> ($countones(out_cr0[3:1]) == 1 && !out_cr0[0]));  // R9

   if (REG_OUT) begin : g_seq
      AST_REJECT_UNKNOWN: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !c_known) |=> (!out_valid && !out_cr0_we));  // R1
      AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && c_known) |=> out_valid);  // R2
      AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> (!out_valid && !out_cr0_we));  // R2
      AST_WORD_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && c_word) |=> (out_result[DW-1:DW/2] == '0));  // R5
      AST_WORD_NEVER_NEG: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && c_word) |=> !out_cr0[3]);  // R9
      AST_DW_LEFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && c_dword) |=>
            ((out_result & ~({DW{1'b1}} >> $past(c_mb))) == '0));  // R6
      AST_RC_GATES_CR0: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && c_known) |=> (out_cr0_we == $past(in_insn[0])));  // R9
   end

endmodule

bind rotmask_unit rotmask_unit_chk #(
   .DW(DW), .IW(IW), .REG_OUT(REG_OUT), .OPC_WORD(OPC_WORD), .OPC_DWORD(OPC_DWORD)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_insn   (in_insn),
   .out_valid (out_valid),
   .out_result(out_result),
   .out_cr0_we(out_cr0_we),
   .out_cr0   (out_cr0)
);

// File: tb/rotmask_unit_tb.sv
module rotmask_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_insn = '0;
   logic [63:0] in_src = '0;
   logic        out_valid;
   logic [63:0] out_result;
   logic        out_cr0_we;
   logic [3:0]  out_cr0;

   int nvec = 0;
   int nfail = 0;
   int cycles = 0;
   logic [63:0] lcg = 64'h0123_4567_89AB_CDEF;

   always #10 clk = ~clk;

   rotmask_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
      .in_src(in_src), .out_valid(out_valid), .out_result(out_result),
      .out_cr0_we(out_cr0_we), .out_cr0(out_cr0)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles == 190000) begin
         nfail++;
         $display("FAIL watchdog R2: actual %0d cycles, expected completion earlier", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   function automatic logic [31:0] enc_word(int sh, int mb, int me, bit rc);
      return {6'd21, 5'd3, 5'd4, 5'(sh), 5'(mb), 5'(me), rc};
   endfunction

   function automatic logic [31:0] enc_dw(int sh, int mb, bit rc);
      logic [5:0] s6 = 6'(sh);
      logic [5:0] m6 = 6'(mb);
      return {6'd30, 5'd3, 5'd4, s6[4:0], m6[4:0], m6[5], 3'b000, s6[5], rc};
   endfunction

   function automatic logic [63:0] exp_word(logic [63:0] s, int sh, int mb, int me);
      logic [31:0] w = s[31:0];
      logic [31:0] r = (sh == 0) ? w : ((w << sh) | (w >> (32 - sh)));
      logic [31:0] a = 32'hFFFF_FFFF >> mb;
      logic [31:0] b = 32'hFFFF_FFFF << (31 - me);
      logic [31:0] m = (mb <= me) ? (a & b) : (a | b);
      return {32'h0, r & m};
   endfunction

   function automatic logic [63:0] exp_dw(logic [63:0] s, int sh, int mb);
      logic [63:0] r = (sh == 0) ? s : ((s << sh) | (s >> (64 - sh)));
      return r & (64'hFFFF_FFFF_FFFF_FFFF >> mb);
   endfunction

   function automatic logic [3:0] exp_cr(logic [63:0] r);
      if ($signed(r) < 0) return 4'b1000;
      if (r == 64'd0)     return 4'b0010;
      return 4'b0100;
   endfunction

   function automatic logic [63:0] next_src();
      lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
      return lcg;
   endfunction

   task automatic apply(input logic [31:0] insn, input logic [63:0] src, input string tag,
                        input bit ev, input logic [63:0] er, input bit ew);
      logic [3:0] ec = exp_cr(er);
      @(negedge clk);
      in_valid = 1'b1;
      in_insn  = insn;
      in_src   = src;
      @(negedge clk);
      nvec++;
      if (out_valid !== ev || (!ev && out_cr0_we !== 1'b0) ||
          (ev && (out_result !== er || out_cr0_we !== ew || (ew && out_cr0 !== ec)))) begin
         nfail++;
         $display("FAIL %s: actual v=%b res=%h we=%b cr=%b, expected v=%b res=%h we=%b cr=%b",
                  tag, out_valid, out_result, out_cr0_we, out_cr0, ev, er, ew, ec);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      logic [63:0] s;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: reset state
      nvec++;
      if (out_valid !== 1'b0 || out_cr0_we !== 1'b0 || out_result !== 64'd0) begin
         nfail++;
         $display("FAIL R2 reset: actual v=%b we=%b res=%h, expected 0 0 0",
                  out_valid, out_cr0_we, out_result);
      end

      // R2: latency, nothing before the edge
      in_valid = 1'b1;
      in_insn  = enc_word(4, 0, 31, 1'b0);
      in_src   = 64'h1;
      #1;
      nvec++;
      if (out_valid !== 1'b0) begin
         nfail++;
         $display("FAIL R2 early: actual v=%b, expected 0", out_valid);
      end
      @(negedge clk);
      nvec++;
      if (out_valid !== 1'b1 || out_result !== 64'h10) begin
         nfail++;
         $display("FAIL R2 latency: actual v=%b res=%h, expected 1 %h", out_valid, out_result, 64'h10);
      end
      idle();
      @(negedge clk);
      nvec++;
      if (out_valid !== 1'b0) begin
         nfail++;
         $display("FAIL R2 idle: actual v=%b, expected 0", out_valid);
      end

      // R8: example vector
      apply(enc_word(27, 31, 31, 1'b1), 64'h1122_3344_5566_77A8, "R8 example",
            1'b1, 64'h1, 1'b1);

      // R7: right shifts as rotate plus mask
      for (int n = 1; n < 32; n++) begin
         s = next_src();
         apply(enc_word(32 - n, n, 31, 1'b0), s, "R7 word shift",
               1'b1, {32'h0, s[31:0] >> n}, 1'b0);
      end
      for (int n = 1; n < 64; n++) begin
         s = next_src();
         apply(enc_dw(64 - n, n, 1'b0), s, "R7 dword shift", 1'b1, s >> n, 1'b0);
      end

      // R5: upper source word ignored
      apply(enc_word(9, 2, 29, 1'b1), 64'hFFFF_FFFF_89AB_CDEF, "R5 upper ignored",
            1'b1, exp_word(64'h0, 9, 2, 29) | exp_word(64'h89AB_CDEF, 9, 2, 29), 1'b1);
      apply(enc_word(9, 2, 29, 1'b1), 64'h0000_0000_89AB_CDEF, "R5 upper ignored",
            1'b1, exp_word(64'h89AB_CDEF, 9, 2, 29), 1'b1);

      // R3, R4, R5, R9: full word-form sweep
      for (int sh = 0; sh < 32; sh++)
         for (int mb = 0; mb < 32; mb++)
            for (int me = 0; me < 32; me++) begin
               bit rc = 1'((sh + mb + me) & 1);
               s = next_src();
               apply(enc_word(sh, mb, me, rc), s, (mb <= me) ? "R3 R5 R9 word" : "R4 R5 R9 wrap",
                     1'b1, exp_word(s, sh, mb, me), rc);
            end

      // R6, R9: full doubleword sweep
      for (int sh = 0; sh < 64; sh++)
         for (int mb = 0; mb < 64; mb++) begin
            bit rc = 1'((sh ^ mb) & 1);
            s = next_src();
            if (mb == 0 && sh == 5) s = 64'h8000_0000_0000_0000 >> 5;
            apply(enc_dw(sh, mb, rc), s, "R6 R9 dword", 1'b1, exp_dw(s, sh, mb), rc);
         end

      // R1: rejected encodings
      for (int op = 0; op < 64; op++) begin
         if (op != 21 && op != 30)
            apply({6'(op), 26'h3FF_FFFF}, next_src(), "R1 bad opcode", 1'b0, 64'h0, 1'b0);
      end
      for (int xo = 1; xo < 8; xo++)
         apply(enc_dw(7, 3, 1'b1) | {27'h0, 3'(xo), 2'b00}, next_src(), "R1 bad subcode",
               1'b0, 64'h0, 1'b0);
      idle();
      @(negedge clk);

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

endmodule